// File: doc/BRIEF.md
# I/O Window Address Translator

This block sits between a big-endian processor bus and a little-endian port-addressed I/O space. The processor sees an 8 MB aperture at 0x8000_0000. Any access that falls inside it is turned into a port access: the block works out a 16-bit port number, corrects the byte order of the data, sends the request out on the I/O side and then returns the completion to the processor.

A mode input picks one of two ways to form the port number. With the mode at 0, the aperture acts as a flat 64 KB port space and the low bits of the offset are used as they are. With the mode at 1, the port space is spread over the aperture at one 4 KB page for every 32 ports. The block packs the page number and the low five offset bits back together to form the port. Only one access is in flight at a time. An access outside the aperture, or one with a reserved size code, never reaches the I/O side and is answered by the block itself.

Top module: `iowin_xlate`

## Requirements
- R1: A request whose address lies in 0x8000_0000 to 0x807F_FFFF is forwarded to the I/O side. Any other address is not forwarded: io_req_valid stays low, cpu_rsp_valid pulses in the cycle after acceptance, and a read returns 0xFFFF_FFFF.
- R2: With map_sparse=0 at acceptance, io_req_addr equals bits 15:0 of the address.
- R3: With map_sparse=1 at acceptance, io_req_addr equals (offset & 0x1F) | ((offset & 0x7FF000) >> 7), where offset is the address minus 0x8000_0000.
- R4: For size code 0 (byte), data is carried in bits 7:0 with no swap in either direction, and bits 31:8 are driven to zero.
- R5: For size code 1 (16-bit), the two bytes in bits 15:0 are exchanged on write data and on read data, and bits 31:16 are driven to zero.
- R6: For size code 2 (32-bit), the four bytes are reversed on write data and on read data.
- R7: Size code 3 is reserved. Such a request is not forwarded and is answered like an out-of-window access.
- R8: Once io_req_valid is raised, it stays high with its address, data, size and direction unchanged until io_req_ready is sampled high. cpu_req_ready is low from acceptance until the response has been delivered.
- R9: io_req_valid rises in the cycle after acceptance. cpu_rsp_valid is a one-cycle pulse. For a write, it comes in the cycle after io_req_ready. For a read, it comes in the cycle after io_rsp_valid and carries the swapped read data.
- R10: After the response pulse, cpu_req_ready is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sparse | input | 1 | Mapping mode: 0 flat 64 KB, 1 page-spread |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_write | input | 1 | 1 write, 0 read |
| cpu_req_addr | input | 32 | Processor byte address |
| cpu_req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| cpu_req_wdata | input | 32 | Write data, big-endian, right-justified |
| cpu_rsp_valid | output | 1 | Completion pulse |
| cpu_rsp_rdata | output | 32 | Read data returned to the processor |
| io_req_valid | output | 1 | Port request present |
| io_req_ready | input | 1 | I/O side accepts the request |
| io_req_write | output | 1 | Port request direction |
| io_req_addr | output | 16 | Translated port number |
| io_req_size | output | 2 | Port access size |
| io_req_wdata | output | 32 | Write data, little-endian |
| io_rsp_valid | input | 1 | Read data from the I/O side is present |
| io_rsp_rdata | input | 32 | Read data from the I/O side |

## Verification
The bench uses offsets near the page and low-field boundaries in both modes. A design with a wrong shift or mask in the spread packing would send a neighbouring or aliased port number, and one that sampled the mode late would mix the two layouts. It checks every size code in both directions, along with the upper bytes that must be zero, so a swap applied to the wrong lanes, or a byte access that gets swapped, changes the data seen at the port. It also stalls the I/O side and sends addresses just outside the aperture and the reserved size. A design that let the request drift while stalled, leaked a stray request, or sent a late or doubled response pulse would show up there.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } xlate_state_e;
endpackage

// File: rtl/iowin_addr_map.sv
module iowin_addr_map #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
  parameter int          WIN_BITS   = 23,
  parameter int          IO_AW      = 16,
  parameter int          PAGE_SHIFT = 12,
  parameter int          LOW_BITS   = 5
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              sparse,
  output logic              in_win,
  output logic [IO_AW-1:0]  io_addr
);
  localparam int PAGE_BITS = WIN_BITS - PAGE_SHIFT;
  localparam int PACK_W    = PAGE_BITS + LOW_BITS;

  logic [WIN_BITS-1:0] offset;
  logic [PACK_W-1:0]   packed_port;
  logic [IO_AW-1:0]    flat_port;

  assign offset      = cpu_addr[WIN_BITS-1:0];
  assign in_win      = (cpu_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
  assign packed_port = {offset[WIN_BITS-1:PAGE_SHIFT], offset[LOW_BITS-1:0]};
  assign flat_port   = offset[IO_AW-1:0];

  always_comb begin
    if (sparse) io_addr = IO_AW'(packed_port);
    else        io_addr = flat_port;
  end
endmodule

// File: rtl/iowin_lane_swap.sv
module iowin_lane_swap
  import iowin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] rev_all;

  for (genvar b = 0; b < NB; b++) begin : g_rev
    assign rev_all[8*b +: 8] = din[8*(NB-1-b) +: 8];
  end

  always_comb begin
    dout = '0;
    unique case (xfer_size_e'(size))
      SZ_BYTE: dout[7:0]  = din[7:0];
      SZ_HALF: dout[15:0] = {din[7:0], din[15:8]};
      SZ_WORD: dout       = rev_all;
      default: dout       = '0;
    endcase
  end
endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate
  import iowin_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
  parameter int          WIN_BITS   = 23,
  parameter int          IO_AW      = 16,
  parameter int          PAGE_SHIFT = 12,
  parameter int          LOW_BITS   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_sparse,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [1:0]        cpu_req_size,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              io_req_valid,
  input  logic              io_req_ready,
  output logic              io_req_write,
  output logic [IO_AW-1:0]  io_req_addr,
  output logic [1:0]        io_req_size,
  output logic [DATA_W-1:0] io_req_wdata,
  input  logic              io_rsp_valid,
  input  logic [DATA_W-1:0] io_rsp_rdata
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  logic             in_win;
  logic [IO_AW-1:0] port_addr;
  logic [DATA_W-1:0] wdata_le, rdata_be;

  iowin_addr_map #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS),
    .IO_AW(IO_AW), .PAGE_SHIFT(PAGE_SHIFT), .LOW_BITS(LOW_BITS)
  ) u_map (
    .cpu_addr(cpu_req_addr),
    .sparse  (map_sparse),
    .in_win  (in_win),
    .io_addr (port_addr)
  );

  iowin_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
    .size(cpu_req_size), .din(cpu_req_wdata), .dout(wdata_le)
  );

  // registered state
  xlate_state_e      state_q, state_d;
  logic [IO_AW-1:0]  addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        size_q;
  logic              write_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              cap_en, rdata_en, forward;

  iowin_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
    .size(size_q), .din(io_rsp_rdata), .dout(rdata_be)
  );

  assign forward = in_win && (xfer_size_e'(cpu_req_size) != SZ_RSVD);
  assign cap_en  = (state_q == ST_IDLE) && cpu_req_valid;

  // next state
  always_comb begin
    state_d  = state_q;
    rdata_d  = rdata_q;
    rdata_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req_valid) begin
          if (forward) begin
            state_d = ST_ISSUE;
          end else begin
            state_d  = ST_DONE;
            rdata_d  = '1;
            rdata_en = 1'b1;
          end
        end
      end
      ST_ISSUE: begin
        if (io_req_ready) begin
          if (write_q) begin
            state_d  = ST_DONE;
            rdata_d  = '0;
            rdata_en = 1'b1;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (io_rsp_valid) begin
          state_d  = ST_DONE;
          rdata_d  = rdata_be;
          rdata_en = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
    end else if (cap_en) begin
      addr_q  <= port_addr;
      wdata_q <= wdata_le;
      size_q  <= cpu_req_size;
      write_q <= cpu_req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_DONE);
  assign cpu_rsp_rdata = rdata_q;
  assign io_req_valid  = (state_q == ST_ISSUE);
  assign io_req_addr   = addr_q;
  assign io_req_wdata  = wdata_q;
  assign io_req_size   = size_q;
  assign io_req_write  = write_q;

  // checks
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    io_req_valid && !io_req_ready |=> io_req_valid && $stable(io_req_addr)
      && $stable(io_req_wdata) && $stable(io_req_size) && $stable(io_req_write));

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    io_req_valid |-> !cpu_req_ready);

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    cpu_rsp_valid |=> !cpu_rsp_valid && cpu_req_ready);

  p_issue_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(io_req_valid) |-> $past(cpu_req_valid && cpu_req_ready));

  p_miss_local_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    cpu_req_valid && cpu_req_ready && !in_win |=> !io_req_valid && cpu_rsp_valid);

  p_rsvd_local_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    cpu_req_valid && cpu_req_ready && (cpu_req_size == 2'd3) |=> !io_req_valid && cpu_rsp_valid);
endmodule

// File: tb/iowin_xlate_test.sv
`timescale 1ns/1ps
module iowin_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_sparse = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic [1:0]  cpu_req_size = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        io_req_valid;
  logic        io_req_ready = 1'b0;
  logic        io_req_write;
  logic [15:0] io_req_addr;
  logic [1:0]  io_req_size;
  logic [31:0] io_req_wdata;
  logic        io_rsp_valid = 1'b0;
  logic [31:0] io_rsp_rdata = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  iowin_xlate uut (
    .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_size(cpu_req_size), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_req_write(io_req_write), .io_req_addr(io_req_addr),
    .io_req_size(io_req_size), .io_req_wdata(io_req_wdata),
    .io_rsp_valid(io_rsp_valid), .io_rsp_rdata(io_rsp_rdata)
  );

  function automatic logic [15:0] exp_port(input logic sparse, input logic [31:0] a);
    logic [31:0] off;
    off = a & 32'h007F_FFFF;
    if (sparse) return 16'((off & 32'h1F) | ((off & 32'h007F_F000) >> 7));
    return off[15:0];
  endfunction

  function automatic logic [31:0] exp_swap(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0: return {24'h0, d[7:0]};
      2'd1: return {16'h0, d[7:0], d[15:8]};
      2'd2: return {d[7:0], d[15:8], d[23:16], d[31:24]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_fwd(input logic [31:0] a, input logic [1:0] sz);
    return (a[31:23] == 9'h100) && (sz != 2'd3);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic sparse, input logic [31:0] a, input logic [1:0] sz,
                        input logic wr, input logic [31:0] d, input int stall,
                        input int lat);
    logic fwd;
    fwd = exp_fwd(a, sz);
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R10 ready idle", 32'(cpu_req_ready), 32'h1);
    map_sparse = sparse; cpu_req_valid = 1'b1; cpu_req_addr = a;
    cpu_req_size = sz; cpu_req_write = wr; cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0; map_sparse = ~sparse; cpu_req_wdata = ~d;
    if (!fwd) begin
      check(io_req_valid == 1'b0, (sz == 2'd3) ? "R7 not forwarded" : "R1 not forwarded",
            32'(io_req_valid), 32'h0);
      check(cpu_rsp_valid == 1'b1, "R1 local rsp", 32'(cpu_rsp_valid), 32'h1);
      if (!wr) check(cpu_rsp_rdata == 32'hFFFF_FFFF, (sz == 2'd3) ? "R7 ones" : "R1 ones",
                     cpu_rsp_rdata, 32'hFFFF_FFFF);
    end else begin
      check(io_req_valid == 1'b1, "R9 issue next cycle", 32'(io_req_valid), 32'h1);
      check(io_req_addr == exp_port(sparse, a), sparse ? "R3 sparse port" : "R2 flat port",
            32'(io_req_addr), 32'(exp_port(sparse, a)));
      check(io_req_size == sz && io_req_write == wr, "R8 size/dir",
            {29'h0, io_req_write, io_req_size}, {29'h0, wr, sz});
      if (wr) check(io_req_wdata == exp_swap(sz, d),
                    (sz == 2'd0) ? "R4 wdata" : (sz == 2'd1) ? "R5 wdata" : "R6 wdata",
                    io_req_wdata, exp_swap(sz, d));
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        check(io_req_valid && io_req_addr == exp_port(sparse, a) && !cpu_req_ready,
              "R8 hold", 32'(io_req_addr), 32'(exp_port(sparse, a)));
      end
      io_req_ready = 1'b1;
      @(negedge clk);
      io_req_ready = 1'b0;
      if (wr) begin
        check(cpu_rsp_valid == 1'b1, "R9 write rsp", 32'(cpu_rsp_valid), 32'h1);
      end else begin
        check(!io_req_valid && !cpu_rsp_valid, "R9 read wait",
              {30'h0, io_req_valid, cpu_rsp_valid}, 32'h0);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          check(!cpu_rsp_valid && !cpu_req_ready, "R8 busy", 32'(cpu_rsp_valid), 32'h0);
        end
        io_rsp_valid = 1'b1; io_rsp_rdata = d;
        @(negedge clk);
        io_rsp_valid = 1'b0; io_rsp_rdata = ~d;
        check(cpu_rsp_valid == 1'b1, "R9 read rsp", 32'(cpu_rsp_valid), 32'h1);
        check(cpu_rsp_rdata == exp_swap(sz, d),
              (sz == 2'd0) ? "R4 rdata" : (sz == 2'd1) ? "R5 rdata" : "R6 rdata",
              cpu_rsp_rdata, exp_swap(sz, d));
      end
    end
    @(negedge clk);
    check(!cpu_rsp_valid && cpu_req_ready && !io_req_valid, "R10 back to idle",
          {29'h0, cpu_rsp_valid, cpu_req_ready, io_req_valid}, 32'h2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] a, d;
    logic [1:0]  sz;
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check(cpu_rsp_valid == 1'b0 && io_req_valid == 1'b0, "R9 reset quiet",
          {30'h0, cpu_rsp_valid, io_req_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cpu_req_ready == 1'b1, "R10 ready after reset", 32'(cpu_req_ready), 32'h1);

    // directed corners
    access(1'b0, 32'h8000_0000, 2'd0, 1'b1, 32'hAABB_CC5A, 0, 0);
    access(1'b0, 32'h807F_FFFF, 2'd0, 1'b0, 32'h1234_56C3, 2, 1);
    access(1'b0, 32'h8001_2345, 2'd1, 1'b1, 32'hDEAD_BEEF, 1, 0);
    access(1'b1, 32'h8000_101F, 2'd1, 1'b0, 32'h0102_0304, 0, 2);
    access(1'b1, 32'h807F_F01F, 2'd2, 1'b1, 32'h1122_3344, 3, 0);
    access(1'b1, 32'h8000_0FE0, 2'd2, 1'b0, 32'hA1B2_C3D4, 0, 0);
    access(1'b1, 32'h8000_0020, 2'd0, 1'b0, 32'h0000_0077, 0, 0);
    access(1'b0, 32'h7FFF_FFFF, 2'd2, 1'b0, 32'h0, 0, 0);
    access(1'b0, 32'h8080_0000, 2'd1, 1'b0, 32'h0, 0, 0);
    access(1'b1, 32'h8000_4000, 2'd3, 1'b0, 32'h0, 0, 0);
    access(1'b0, 32'h8000_4000, 2'd3, 1'b1, 32'h5555_AAAA, 0, 0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      d  = $urandom;
      sz = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) a = $urandom;
      else a = 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
      access(1'($urandom), a, sz, 1'($urandom), d,
             int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule